// File: doc/BRIEF.md
# Charger-Port Configuration Target on a Two-Wire Serial Bus

This block is the serial-bus register target for one port of a two-port USB charger-emulation controller. It watches the bus clock and data lines after a synchronizer and drives only an open-drain pull-down on the data line. It holds a nine-entry byte map. Six entries are writable control bytes, and their values appear on output pins for the charging logic. Two entries mirror status bytes that the rest of the chip supplies. One entry is a fixed identity byte.

A controller writes by sending the target address with the write bit, then a register pointer, then any number of data bytes. A read is a pointer write, a repeated START, then the address with the read bit. The target then returns bytes until the controller answers with a NAK. After each data byte the pointer steps up by one. The exception is a pointer of zero, which stays at zero so that the identity byte can be polled.

There is no streamed data path in this block. Every port is a plain level signal sampled on the system clock, so no back-pressure rules apply. The system clock must run at least 16 times faster than the bus clock.

Top module: `chg_port_i2c_target`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and the control outputs hold their reset values: ctrl1 0xA7, ctrl2 0x50, ctrl3 0xE9, ctrl4 0x00, ctrl5 0x6B, irq_mask 0x00.
- R2: The target answers only to the 7-bit address {0,1,0,PORT_B,1,0,addr_strap_i}. Bit 0 of the address byte is R/W, with 1 meaning read. Any other address gets a NAK, and the target then ignores the bus until the next START.
- R3: The pointer byte (the first byte after the address with the write bit) is acknowledged and loaded only when it is below 9. Otherwise it gets a NAK, the pointer keeps its old value, and the target ignores the bus until the next START.
- R4: A data byte written while the pointer is 1, 2, 3, 4, 5 or 8 replaces that register. Registers 1 to 5 drive ctrl1_o to ctrl5_o, and register 8 drives irq_mask_o.
- R5: In a burst write, each acknowledged data byte advances the pointer by one, so consecutive bytes land in consecutive registers.
- R6: When the pointer is 0, it does not advance after a data byte. Burst reads at 0 return 0x11 every time, and burst writes at 0 are acknowledged and have no effect on any register.
- R7: Registers 0, 6 and 7 are read-only. Writes to them are acknowledged and discarded. Reads return 0x11, `evt_flags_i` and `live_stat_i` respectively.
- R8: After a repeated START with the read bit, the target sends the register at the pointer MSB first. The pointer advances after each byte (R6 aside), and the target keeps sending bytes while the controller acknowledges them. A NAK from the controller ends the transfer.
- R9: A data byte written when the pointer has advanced to 9 or beyond gets a NAK and is discarded. A read from such a pointer returns 0x00.
- R10: A START or STOP in the middle of a byte abandons that byte: no register changes, and a START restarts address reception.
- R11: The target acknowledges by pulling SDA low from the SCL falling edge after the 8th bit until the falling edge after the 9th. `sda_pull_o` changes only after an SCL falling edge, START or STOP, and never pulls SDA during bits the controller sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_strap_i | input | 1 | Strap that sets the address LSB |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| evt_flags_i | input | 8 | Byte returned for register 6 |
| live_stat_i | input | 8 | Byte returned for register 7 |
| ctrl1_o | output | 8 | Register 1 value |
| ctrl2_o | output | 8 | Register 2 value |
| ctrl3_o | output | 8 | Register 3 value |
| ctrl4_o | output | 8 | Register 4 value |
| ctrl5_o | output | 8 | Register 5 value |
| irq_mask_o | output | 8 | Register 8 value |

## Verification
The assertions assume a bus that follows the line discipline. Data changes only while SCL is low, except for START and STOP. Each SCL level lasts several system clocks, so the synchronizer reports one edge per transition. The bench master waits a few clocks after each SCL fall before it moves SDA, and it holds each SCL level for twelve clocks. It never starts a pointer burst that could wrap the 8-bit pointer, and it changes the status inputs and the strap only between transfers.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;
  localparam int NREG = 9;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_WR, PH_RD, PH_SKIP
  } phase_t;

  function automatic logic [7:0] rst_val(input int idx);
    case (idx)
      0: return 8'h11;
      1: return 8'hA7;
      2: return 8'h50;
      3: return 8'hE9;
      5: return 8'h6B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic is_rw(input int idx);
    return !(idx == 0 || idx == 6 || idx == 7);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr_o
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  phase_t     ph_q;
  logic [3:0] bit_cnt;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic       rw_q, mack_q;
  logic       byte_end, slot_end, ptr_ok;

  assign byte_end = scl_fall && (bit_cnt == 4'd8);
  assign slot_end = scl_fall && (bit_cnt == 4'd9);
  assign ptr_ok   = ptr_q < NREG_B;
  assign wr_en    = (ph_q == PH_WR) && byte_end && ptr_ok;
  assign wr_data  = rx_q;
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      bit_cnt  <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (bus_start) begin
      ph_q     <= PH_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (bus_stop) begin
      ph_q     <= PH_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (ph_q != PH_IDLE && ph_q != PH_SKIP) begin
      if (scl_rise && bit_cnt < 4'd9) begin
        bit_cnt <= bit_cnt + 4'd1;
        if (bit_cnt < 4'd8) rx_q <= {rx_q[6:0], sda_s};
        else                mack_q <= ~sda_s;
      end
      if (byte_end) begin
        case (ph_q)
          PH_ADDR: if (rx_q[7:1] == dev_addr) begin
                     sda_pull <= 1'b1;
                     rw_q     <= rx_q[0];
                   end else ph_q <= PH_SKIP;
          PH_PTR:  if (rx_q < NREG_B) begin
                     sda_pull <= 1'b1;
                     ptr_q    <= rx_q;
                   end else ph_q <= PH_SKIP;
          PH_WR:   if (ptr_ok) begin
                     sda_pull <= 1'b1;
                     if (ptr_q != 8'd0) ptr_q <= ptr_q + 8'd1;
                   end else ph_q <= PH_SKIP;
          PH_RD:   begin
                     sda_pull <= 1'b0;
                     if (ptr_q != 8'd0) ptr_q <= ptr_q + 8'd1;
                   end
          default: ;
        endcase
      end else if (slot_end) begin
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        case (ph_q)
          PH_ADDR: if (rw_q) begin
                     ph_q     <= PH_RD;
                     tx_q     <= {rd_data[6:0], 1'b0};
                     sda_pull <= ~rd_data[7];
                   end else ph_q <= PH_PTR;
          PH_PTR:  ph_q <= PH_WR;
          PH_RD:   if (mack_q) begin
                     tx_q     <= {rd_data[6:0], 1'b0};
                     sda_pull <= ~rd_data[7];
                   end else ph_q <= PH_SKIP;
          default: ;
        endcase
      end else if (scl_fall && ph_q == PH_RD && bit_cnt != 4'd0) begin
        sda_pull <= ~tx_q[7];
        tx_q     <= {tx_q[6:0], 1'b0};
      end
    end
  end

  // R11
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || bus_start || bus_stop));
  // R6
  ptr_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_WR || ph_q == PH_RD) && byte_end && ptr_q == 8'd0) |=> ptr_q == 8'd0);
  // R2
  addr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR && byte_end && rx_q[7:1] != dev_addr) |=> (!sda_pull && ph_q == PH_SKIP));
  // R3
  ptr_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PTR && byte_end && rx_q >= NREG_B) |=> (!sda_pull && $stable(ptr_q)));
  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (bit_cnt == 4'd0 && ph_q == PH_ADDR));
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           evt_flags,
  input  logic [7:0]           live_stat,
  output logic [NREG-1:0][7:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 6) begin : g_evt
      assign regs_o[g] = evt_flags;
    end else if (g == 7) begin : g_live
      assign regs_o[g] = live_stat;
    end else if (is_rw(g)) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             q <= rst_val(g);
        else if (wr_en && wr_idx == 8'(g))      q <= wr_data;
      end
      assign regs_o[g] = q;
    end else begin : g_const
      assign regs_o[g] = rst_val(g);
    end
  end

  // R9
  wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx < 8'(NREG));
endmodule

// File: rtl/chg_port_i2c_target.sv
module chg_port_i2c_target
  import i2c_regs_pkg::*;
#(
  parameter bit PORT_B      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_strap_i,
  output logic       sda_pull_o,
  input  logic [7:0] evt_flags_i,
  input  logic [7:0] live_stat_i,
  output logic [7:0] ctrl1_o,
  output logic [7:0] ctrl2_o,
  output logic [7:0] ctrl3_o,
  output logic [7:0] ctrl4_o,
  output logic [7:0] ctrl5_o,
  output logic [7:0] irq_mask_o
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [7:0] wr_data, ptr, rd_data;
  logic [6:0] dev_addr;
  logic [NREG-1:0][7:0] regs;

  assign dev_addr = {3'b010, PORT_B, 2'b10, addr_strap_i};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .dev_addr(dev_addr), .rd_data(rd_data), .sda_pull(sda_pull_o),
    .wr_en(wr_en), .wr_data(wr_data), .ptr_o(ptr)
  );

  i2c_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
    .evt_flags(evt_flags_i), .live_stat(live_stat_i), .regs_o(regs)
  );

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (ptr == 8'(i)) rd_data = regs[i];
  end

  assign ctrl1_o    = regs[1];
  assign ctrl2_o    = regs[2];
  assign ctrl3_o    = regs[3];
  assign ctrl4_o    = regs[4];
  assign ctrl5_o    = regs[5];
  assign irq_mask_o = regs[8];
endmodule

// File: tb/tb_chg_port_i2c_target.sv
module tb_chg_port_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 12;
  localparam int Q  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [7:0] evt = 8'h00, live = 8'h00;
  logic sda_pull;
  logic [7:0] c1, c2, c3, c4, c5, msk;
  wire sda_line = sda_m & ~sda_pull;

  chg_port_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_pull_o(sda_pull), .evt_flags_i(evt),
    .live_stat_i(live), .ctrl1_o(c1), .ctrl2_o(c2), .ctrl3_o(c3),
    .ctrl4_o(c4), .ctrl5_o(c5), .irq_mask_o(msk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [9];
  int mptr = 0;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] my_addr();
    return {3'b010, 1'b0, 2'b10, strap};
  endfunction

  function automatic bit rw_reg(input int i);
    return !(i == 0 || i == 6 || i == 7);
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    if (i == 6) return evt;
    if (i == 7) return live;
    if (i < 9)  return mdl[i];
    return 8'h00;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1; tick(HP - Q); scl_m = 1'b1; tick(HP);
    sda_m = 1'b0; tick(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(HP - Q); scl_m = 1'b1; tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      tick(Q); sda_m = b[i]; tick(HP - Q); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit leak;
    leak = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(HP - Q); scl_m = 1'b1;
      tick(HP/2); if (sda_pull) leak = 1'b1; tick(HP/2); scl_m = 1'b0;
    end
    tick(Q); sda_m = 1'b1; tick(HP - Q); scl_m = 1'b1;
    tick(HP/2); ack = !sda_line; tick(HP/2); scl_m = 1'b0;
    chk(!leak, "R11 no pull during controller bits", {7'd0, leak}, 8'h00);
  endtask

  task automatic rbyte(input bit last, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP); scl_m = 1'b1; tick(HP/2); v[i] = sda_line; tick(HP/2); scl_m = 1'b0;
    end
    tick(Q); sda_m = last; tick(HP - Q); scl_m = 1'b1; tick(HP); scl_m = 1'b0;
    tick(Q); sda_m = 1'b1;
  endtask

  task automatic cmp_ports(input string tag);
    chk(c1 == mdl[1], tag, c1, mdl[1]);
    chk(c2 == mdl[2], tag, c2, mdl[2]);
    chk(c3 == mdl[3], tag, c3, mdl[3]);
    chk(c4 == mdl[4], tag, c4, mdl[4]);
    chk(c5 == mdl[5], tag, c5, mdl[5]);
    chk(msk == mdl[8], tag, msk, mdl[8]);
  endtask

  task automatic xfer_write(input logic [6:0] a7, input logic [7:0] p, input int n,
                            input logic [7:0] d [8]);
    bit ack, e;
    bus_start();
    wbyte({a7, 1'b0}, ack);
    e = (a7 == my_addr());
    chk(ack == e, "R2 address ack", {7'd0, ack}, {7'd0, e});
    if (!e) begin bus_stop(); return; end
    wbyte(p, ack);
    e = (p < 9);
    chk(ack == e, "R3 pointer ack", {7'd0, ack}, {7'd0, e});
    if (!e) begin bus_stop(); return; end
    mptr = p;
    for (int k = 0; k < n; k++) begin
      wbyte(d[k], ack);
      e = (mptr < 9);
      chk(ack == e, e ? "R5 data ack" : "R9 data nak past map", {7'd0, ack}, {7'd0, e});
      if (!e) break;
      if (rw_reg(mptr)) mdl[mptr] = d[k];
      if (mptr != 0) mptr++;
    end
    bus_stop();
    cmp_ports("R4 control outputs after write");
  endtask

  task automatic xfer_read(input logic [7:0] p, input int n);
    bit ack, e;
    logic [7:0] v, x;
    bus_start();
    wbyte({my_addr(), 1'b0}, ack);
    chk(ack, "R2 address ack", {7'd0, ack}, 8'h01);
    wbyte(p, ack);
    e = (p < 9);
    chk(ack == e, "R3 pointer ack", {7'd0, ack}, {7'd0, e});
    if (!e) begin bus_stop(); return; end
    mptr = p;
    bus_start();
    wbyte({my_addr(), 1'b1}, ack);
    chk(ack, "R8 read address ack", {7'd0, ack}, 8'h01);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, v);
      x = exp_rd(mptr);
      if (mptr == 0)                    chk(v == x, "R6 read at pointer 0", v, x);
      else if (mptr == 6 || mptr == 7)  chk(v == x, "R7 read-only status", v, x);
      else if (mptr >= 9)               chk(v == x, "R9 read past map", v, x);
      else                              chk(v == x, "R8 read data", v, x);
      if (mptr != 0) mptr++;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1-all act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    bit ack;
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h11; mdl[1] = 8'hA7; mdl[2] = 8'h50; mdl[3] = 8'hE9; mdl[5] = 8'h6B;
    for (int i = 0; i < 8; i++) d[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    chk(sda_pull == 1'b0, "R1 reset pull", {7'd0, sda_pull}, 8'h00);
    cmp_ports("R1 reset values");
    xfer_read(8'd1, 8);
    xfer_read(8'd0, 3);

    d[0] = 8'h3C; d[1] = 8'hC5; d[2] = 8'h0F;
    xfer_write(my_addr(), 8'd2, 3, d);
    xfer_read(8'd2, 3);

    d[0] = 8'h99; d[1] = 8'h98; d[2] = 8'h97;
    xfer_write(my_addr(), 8'd0, 3, d);
    chk(c1 == mdl[1], "R6 write at pointer 0 ignored", c1, mdl[1]);

    d[0] = 8'hFF; d[1] = 8'hFF; d[2] = 8'h5A;
    evt = 8'h3C; live = 8'hC3;
    xfer_write(my_addr(), 8'd6, 3, d);
    xfer_read(8'd6, 3);
    chk(msk == 8'h5A, "R7 write after read-only lands in 8", msk, 8'h5A);

    d[0] = 8'h21; d[1] = 8'h22; d[2] = 8'h23;
    xfer_write(my_addr(), 8'd8, 3, d);
    xfer_read(8'd8, 3);
    xfer_write(my_addr(), 8'd9, 1, d);
    xfer_write(my_addr(), 8'd200, 1, d);

    xfer_write(7'b0101_101, 8'd1, 1, d);
    xfer_write(my_addr() ^ 7'd1, 8'd1, 1, d);
    strap = 1'b1; tick(4);
    d[0] = 8'h77;
    xfer_write(my_addr(), 8'd4, 1, d);
    chk(c4 == 8'h77, "R2 strap selects address", c4, 8'h77);

    bus_start(); wbyte({my_addr(), 1'b0}, ack); wbyte(8'd2, ack);
    send_bits(8'h00, 4);
    bus_stop();
    chk(c2 == mdl[2], "R10 stop abandons partial byte", c2, mdl[2]);
    bus_start(); wbyte({my_addr(), 1'b0}, ack); wbyte(8'd3, ack);
    send_bits(8'h12, 3);
    bus_start(); wbyte({my_addr(), 1'b1}, ack);
    chk(ack, "R10 restart after partial byte", {7'd0, ack}, 8'h01);
    rbyte(1'b1, v);
    chk(v == mdl[3], "R10 partial byte not written", v, mdl[3]);
    bus_stop();

    for (int it = 0; it < 36; it++) begin
      int p, n;
      evt = 8'($urandom); live = 8'($urandom); strap = 1'($urandom);
      p = $urandom % 11; n = 1 + $urandom % 4;
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      tick(4);
      if ($urandom % 2) xfer_write(my_addr(), 8'(p), n, d);
      else              xfer_read(8'(p), n);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule